// File: doc/BRIEF.md
# Seven-Segment Digit Decoder with Zero Suppression

This block turns a four-bit decimal digit code into seven active-low segment drives for a common-anode display. It is purely combinational. Outputs follow the inputs within the same cycle, and no clock is involved. Codes above nine produce a dark digit.

Three control inputs shape the output. A lamp-check input lights every segment so that an operator can confirm that the display works. A zero-suppress input tells the digit that every more significant digit was a suppressed zero. When that input is asserted and the own code is zero, the digit goes dark and passes the same indication on through its suppress output. The suppress output is modelled as a wired-AND node that an external driver may also pull low. Pulling it low acts as a forced-blank request that darkens the digit whatever the other inputs are.

To hide leading zeros, chain several decoders from the most significant digit down. Tie the first digit's suppress input low, and feed each digit's suppress output into the next digit's suppress input.

Top module: `seg7_digit_decoder`

## Requirements
- R1: With all controls inactive (lampCheckN=1, zeroSuppressInN=1, blankForceN=1), codes 0 to 9 drive `segN` as the usual decimal glyphs. Bit 0 is segment a and bit 6 is segment g, and a 0 bit lights a segment. The glyph for 0 is `7'b1000000` and the glyph for 8 is `7'b0000000`.
- R2: The glyph for 6 includes segment a (`7'b0000010`), and the glyph for 9 includes segment d (`7'b0010000`).
- R3: Codes 10 through 15 drive all seven segments off (`7'b1111111`) while lamp check is inactive.
- R4: With blankForceN=1, lampCheckN=0 lights all seven segments (`segN=0`) for any code and any zero-suppress input.
- R5: blankForceN=0 forces `segN=7'b1111111` and `zeroSuppressOutN=0` for every code and every other control value. It takes priority over lamp check.
- R6: zeroSuppressInN=0 with code 0, lampCheckN=1 and blankForceN=1 turns all segments off and drives zeroSuppressOutN=0.
- R7: zeroSuppressOutN is 1 in every case not covered by R5 or R6.
- R8: zeroSuppressInN=0 with a nonzero code leaves the digit decoded as in R1 and R3.
- R9: In a chain, a zero digit is suppressed only when the more significant digit was itself suppressed. A zero that follows a visible digit stays visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digitCode | input | 4 | Digit code, 0 to 15 |
| lampCheckN | input | 1 | Active-low lamp check, lights all segments |
| zeroSuppressInN | input | 1 | Active-low: more significant digits were suppressed zeros |
| blankForceN | input | 1 | Active-low forced blank, the external side of the shared suppress node |
| segN | output | 7 | Active-low segment drives, bit 0 = a through bit 6 = g |
| zeroSuppressOutN | output | 1 | Active-low suppress indication for the next digit |

## Verification
The sweep covers all sixteen codes under all eight control combinations. This separates the priority order of forced blank, lamp check, zero suppression and plain decoding, because each code stays the same while only the winning control changes. The codes above nine set the dark invalid-code glyph apart from suppression, and the nonzero codes under an asserted zero-suppress input show that suppression only affects zero. A two-digit chain with the pairs 0-5, 3-0 and 0-0 tests leading-zero suppression against an embedded zero.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W = 7;
  localparam int LAST_DIGIT = 9;
  localparam logic [SEG_W-1:0] SEG_DARK = {SEG_W{1'b1}};
  localparam logic [SEG_W-1:0] SEG_LIT = {SEG_W{1'b0}};

  typedef struct packed {
    logic blankAll;
    logic lampOn;
  } segStrobe_t;
endpackage

// File: rtl/seg7_ctrl.sv
module seg7_ctrl
  import seg7_pkg::*;
(
  input  logic [CODE_W-1:0] digitCode,
  input  logic              lampCheckN,
  input  logic              zeroSuppressInN,
  input  logic              blankForceN,
  output segStrobe_t        strobe,
  output logic              zeroSuppressOutN
);
  logic codeIsZero;
  logic zeroHit;

  assign codeIsZero = (digitCode == '0);
  // Suppress only a zero behind suppressed digits, and never during lamp check
  assign zeroHit = codeIsZero && !zeroSuppressInN && lampCheckN;

  always_comb begin
    strobe.blankAll = !blankForceN || zeroHit;
    strobe.lampOn   = !lampCheckN && blankForceN;
  end

  // Wired-AND node: internal pull-down or external forced blank
  assign zeroSuppressOutN = blankForceN && !zeroHit;
endmodule

// File: rtl/seg7_datapath.sv
module seg7_datapath
  import seg7_pkg::*;
(
  input  logic [CODE_W-1:0] digitCode,
  input  segStrobe_t        strobe,
  output logic [SEG_W-1:0]  segN
);
  logic [SEG_W-1:0] glyphOn;
  logic [SEG_W-1:0] shownOn;

  // Active-high glyph; bit 0 = a .. bit 6 = g
  always_comb begin
    unique case (digitCode)
      4'd0:    glyphOn = 7'b0111111;
      4'd1:    glyphOn = 7'b0000110;
      4'd2:    glyphOn = 7'b1011011;
      4'd3:    glyphOn = 7'b1001111;
      4'd4:    glyphOn = 7'b1100110;
      4'd5:    glyphOn = 7'b1101101;
      4'd6:    glyphOn = 7'b1111101;
      4'd7:    glyphOn = 7'b0000111;
      4'd8:    glyphOn = 7'b1111111;
      4'd9:    glyphOn = 7'b1101111;
      default: glyphOn = '0;
    endcase
  end

  // Per-segment priority mux: blank, then lamp, then glyph
  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    always_comb begin
      if (strobe.blankAll)    shownOn[s] = 1'b0;
      else if (strobe.lampOn) shownOn[s] = 1'b1;
      else                    shownOn[s] = glyphOn[s];
    end
  end

  assign segN = ~shownOn;
endmodule

// File: rtl/seg7_digit_decoder.sv
module seg7_digit_decoder
  import seg7_pkg::*;
(
  input  logic [3:0] digitCode,
  input  logic       lampCheckN,
  input  logic       zeroSuppressInN,
  input  logic       blankForceN,
  output logic [6:0] segN,
  output logic       zeroSuppressOutN
);
  segStrobe_t strobe;

  seg7_ctrl u_ctrl (
    .digitCode        (digitCode),
    .lampCheckN       (lampCheckN),
    .zeroSuppressInN  (zeroSuppressInN),
    .blankForceN      (blankForceN),
    .strobe           (strobe),
    .zeroSuppressOutN (zeroSuppressOutN)
  );

  seg7_datapath u_dp (
    .digitCode (digitCode),
    .strobe    (strobe),
    .segN      (segN)
  );
endmodule

// File: rtl/seg7_digit_decoder_chk.sv
module seg7_digit_decoder_chk (
  input logic [3:0] digitCode,
  input logic       lampCheckN,
  input logic       zeroSuppressInN,
  input logic       blankForceN,
  input logic [6:0] segN,
  input logic       zeroSuppressOutN
);
  always_comb begin
    // R5: forced blank darkens the digit and pulls the suppress node
    a_r5_force_blank: assert (blankForceN || (segN == 7'h7F && !zeroSuppressOutN));
    // R4: lamp check lights every segment unless forced dark
    a_r4_lamp_check: assert (!(blankForceN && !lampCheckN) || segN == 7'h00);
    // R3: out-of-range codes stay dark without lamp check
    a_r3_invalid_dark: assert (!(lampCheckN && digitCode > 4'd9) || segN == 7'h7F);
    // R6 / R7: suppress output low only for forced blank or a suppressed zero
    a_r7_ripple_high: assert (zeroSuppressOutN || !blankForceN ||
                              (digitCode == 4'd0 && !zeroSuppressInN && lampCheckN));
    // R6: a low suppress output always comes with a dark digit
    a_r6_dark_when_low: assert (zeroSuppressOutN || segN == 7'h7F);
  end
endmodule

bind seg7_digit_decoder seg7_digit_decoder_chk u_chk (
  .digitCode        (digitCode),
  .lampCheckN       (lampCheckN),
  .zeroSuppressInN  (zeroSuppressInN),
  .blankForceN      (blankForceN),
  .segN             (segN),
  .zeroSuppressOutN (zeroSuppressOutN)
);

// File: tb/tb_seg7_digit_decoder.sv
`timescale 1ns/1ps
module tb_seg7_digit_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] code, lowCode;
  logic lampN, zsInN, forceN;
  logic [6:0] segN, lowSegN;
  logic zsOutN, lowZsOutN;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  seg7_digit_decoder dut (
    .digitCode(code), .lampCheckN(lampN), .zeroSuppressInN(zsInN),
    .blankForceN(forceN), .segN(segN), .zeroSuppressOutN(zsOutN));

  seg7_digit_decoder dutLow (
    .digitCode(lowCode), .lampCheckN(1'b1), .zeroSuppressInN(zsOutN),
    .blankForceN(1'b1), .segN(lowSegN), .zeroSuppressOutN(lowZsOutN));

  // Segment-major reference: which digits light each segment
  function automatic logic [6:0] refGlyphN(input int d);
    logic [6:0] on = '0;
    if (d > 9) return 7'h7F;
    on[0] = d inside {0,2,3,5,6,7,8,9};
    on[1] = d inside {0,1,2,3,4,7,8,9};
    on[2] = d inside {0,1,3,4,5,6,7,8,9};
    on[3] = d inside {0,2,3,5,6,8,9};
    on[4] = d inside {0,2,6,8};
    on[5] = d inside {0,4,5,6,8,9};
    on[6] = d inside {2,3,4,5,6,8,9};
    return ~on;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    code = 0; lowCode = 0; lampN = 1; zsInN = 1; forceN = 1;
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 initial zero glyph", {1'b0, segN}, 8'h40);
    check("R7 initial suppress out", {7'b0, zsOutN}, 8'h01);

    // R2: distinctive 6 and 9
    @(posedge clk); code = 6;
    @(negedge clk); check("R2 six has a", {1'b0, segN}, 8'h02);
    @(posedge clk); code = 9;
    @(negedge clk); check("R2 nine has d", {1'b0, segN}, 8'h10);

    // Exhaustive sweep: R1 R3 R4 R5 R6 R7 R8
    for (int f = 0; f < 2; f++)
      for (int l = 0; l < 2; l++)
        for (int z = 0; z < 2; z++)
          for (int c = 0; c < 16; c++) begin
            logic [6:0] expSeg;
            logic expZ;
            string req;
            @(posedge clk);
            code = 4'(c); lampN = l[0]; zsInN = z[0]; forceN = f[0];
            if (f == 0) begin
              expSeg = 7'h7F; expZ = 0; req = "R5 forced blank";
            end else if (l == 0) begin
              expSeg = 7'h00; expZ = 1; req = "R4 lamp check";
            end else if (c == 0 && z == 0) begin
              expSeg = 7'h7F; expZ = 0; req = "R6 zero suppressed";
            end else begin
              expSeg = refGlyphN(c); expZ = 1;
              req = (c > 9) ? "R3 invalid dark" : (z == 0) ? "R8 nonzero under suppress" : "R1 decode";
            end
            @(negedge clk);
            check(req, {1'b0, segN}, {1'b0, expSeg});
            check(expZ ? "R7 suppress out high" : "R5/R6 suppress out low",
                  {7'b0, zsOutN}, {7'b0, expZ});
          end

    // R9 chain: upper digit leads, lower fed from its suppress output
    @(posedge clk); code = 0; lowCode = 5; lampN = 1; zsInN = 0; forceN = 1;
    @(negedge clk);
    check("R9 upper zero dark", {1'b0, segN}, 8'h7F);
    check("R9 lower five shown", {1'b0, lowSegN}, {1'b0, refGlyphN(5)});
    @(posedge clk); code = 3; lowCode = 0;
    @(negedge clk);
    check("R9 zero after visible digit shown", {1'b0, lowSegN}, 8'h40);
    check("R9 lower suppress out high", {7'b0, lowZsOutN}, 8'h01);
    @(posedge clk); code = 0; lowCode = 0;
    @(negedge clk);
    check("R9 chained zero dark", {1'b0, lowSegN}, 8'h7F);
    check("R9 chained suppress out low", {7'b0, lowZsOutN}, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule